// File: doc/BRIEF.md
# Serial Test-Pattern Source with Impairment Injection

This block is a bit-serial stimulus generator for link and receiver testing. On every clock cycle in which its step enable is high it emits one bit. The bit comes from one of four maximal-length pseudo-random sequences or from one of eight fixed user patterns. The output appears one cycle later with a valid flag, so a downstream serialiser or checker can pace the source at any rate, gaps included.

On top of the clean sequence the block can spoil the stream on purpose. A command pulse flips the next emitted bit. A programmable divider flips one bit out of every N. In the pseudo-random modes a burst of zeros is spliced in once per sequence period while the shift register holds its state. A final polarity control inverts everything. Line coding, clock generation and register access are handled elsewhere.

Top module: `patsrc_top`

## Requirements
- R1: Each cycle with `step_en` high produces, on the next cycle, `bit_vld` = 1 and a new `bit_out`. Each cycle with `step_en` low produces `bit_vld` = 0 on the next cycle. While `rst_n` is low, `bit_vld` and `bit_out` are 0.
- R2: `mode_sel` values 0, 1, 2 and 3 pick the sequence of order n = 7, 11, 15 and 23, with feedback tap t = 6, 9, 14 and 18 (polynomial x^n + x^t + 1). The n-bit state starts at all ones. Each step emits state bit n-1, then shifts the state left by one and inserts bit (n-1) XOR bit (t-1) at bit 0.
- R3: When `mode_sel[2]` = 1, the preset chosen by `preset_idx` is played. Preset k has the pattern `USER_PAT[32k+31:32k]` and the length L = `USER_LEN[6k+5:6k]`, with 3 <= L <= 32. The bits are emitted from bit 0 upward to bit L-1, and the pattern then wraps to bit 0.
- R4: Any change of `mode_sel` or `preset_idx` against the previous cycle restarts the block in that cycle. The sequence state returns to all ones, the pattern position returns to bit 0, and the period count and any zero run are cleared. A bit emitted in that cycle is the first bit of the new sequence.
- R5: In the sequence modes, after every 2^n-1 emitted sequence bits, Z zero bits follow, and the shift register does not advance during them. Z is `zrun_len` when it lies in 8..2040, Z is 2040 when `zrun_len` is above 2040, and there is no zero run when `zrun_len` is below 8.
- R6: In user-pattern mode no zero run is inserted and `zrun_len` has no effect.
- R7: A pulse on `err_one` flips the first bit emitted in that cycle or any later cycle. Further pulses that arrive before that flip happens are ignored.
- R8: With `err_div` = N > 0, the N-th emitted bit, the 2N-th emitted bit and so on are flipped, counting from reset or from the moment N became nonzero. With N = 0 there are no periodic flips.
- R9: When a single-shot flip and a periodic flip fall on the same bit, that bit is flipped once. Flips apply to zero-run bits as well.
- R10: `invert` = 1 inverts every emitted bit. The inversion is applied after the error flips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Emit one bit this cycle |
| mode_sel | input | 3 | 0..3: sequence order 7/11/15/23; bit 2 set: user preset |
| preset_idx | input | 3 | User preset number |
| err_one | input | 1 | Single-bit error request |
| err_div | input | 32 | Periodic error spacing N (0 disables) |
| zrun_len | input | 11 | Zero-run length |
| invert | input | 1 | Output polarity |
| bit_out | output | 1 | Emitted bit |
| bit_vld | output | 1 | `bit_out` is new this cycle |

## Verification
The bench targets the period boundary of the order-7 sequence with zero runs of 8 bits, of a disabled length and of an over-range length that must clamp to 2040. A design that advanced the register during the run, or miscounted the period, would put the zeros at the wrong point and then shift the whole pseudo-random stream. Single-error pulses are sent back to back and during stalls of `step_en`, so a design that flipped on an idle cycle or honoured a second pulse would show an extra inverted bit. Divider values of 1, 5 and 37 check the every-N spacing and the overlap with single flips. Presets of lengths 3 through 32 and mode changes in the middle of a stream check wrap-around and restart, where a design with an off-by-one wrap or a stale pointer would emit a displaced bit.

// File: rtl/patsrc_pkg.sv
package patsrc_pkg;

   localparam int LFSR_W   = 23;
   localparam int ZRUN_MIN = 8;
   localparam int ZRUN_MAX = 2040;
   localparam int NUM_POLY = 4;

   typedef enum logic [1:0] {
      SEQ_O7  = 2'd0,
      SEQ_O11 = 2'd1,
      SEQ_O15 = 2'd2,
      SEQ_O23 = 2'd3
   } seq_order_e;

   function automatic int poly_order(input int idx);
      case (idx)
         0:       return 7;
         1:       return 11;
         2:       return 15;
         default: return 23;
      endcase
   endfunction

   function automatic int poly_tap(input int idx);
      case (idx)
         0:       return 6;
         1:       return 9;
         2:       return 14;
         default: return 18;
      endcase
   endfunction

endpackage

// File: rtl/patsrc_prbs.sv
module patsrc_prbs
   import patsrc_pkg::*;
#(
   parameter int ZRUN_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              restart,
   input  seq_order_e        order,
   input  logic [ZRUN_W-1:0] zrun_len,
   output logic              raw_bit,
   output logic              zrun_act
);

   localparam int W = LFSR_W;

   if (ZRUN_W < $clog2(ZRUN_MAX + 1)) begin : g_bad_zrun_w
      $error("ZRUN_W too narrow for the maximum zero run");
   end

   logic [W-1:0]      st_q, st_cur;
   logic [W-1:0]      pcnt_q, pcnt_cur;
   logic [ZRUN_W-1:0] zcnt_q, zcnt_cur;
   logic              inz_q, inz_cur;
   logic [ZRUN_W-1:0] zl_eff;
   logic              zrun_on;

   logic [W-1:0]          nxt_v  [NUM_POLY];
   logic [NUM_POLY-1:0]   msb_v;
   logic [NUM_POLY-1:0]   last_v;

   assign st_cur   = restart ? '1 : st_q;
   assign pcnt_cur = restart ? '0 : pcnt_q;
   assign zcnt_cur = restart ? '0 : zcnt_q;
   assign inz_cur  = restart ? 1'b0 : inz_q;

   for (genvar g = 0; g < NUM_POLY; g++) begin : g_poly
      localparam int N   = poly_order(g);
      localparam int T   = poly_tap(g);
      localparam int PER = (1 << N) - 1;
      always_comb begin
         nxt_v[g]        = st_cur;
         nxt_v[g][N-1:0] = {st_cur[N-2:0], st_cur[N-1] ^ st_cur[T-1]};
      end
      assign msb_v[g]  = st_cur[N-1];
      assign last_v[g] = (pcnt_cur == W'(PER - 1));
   end

   always_comb begin
      if (zrun_len < ZRUN_W'(ZRUN_MIN))      zl_eff = '0;
      else if (zrun_len > ZRUN_W'(ZRUN_MAX)) zl_eff = ZRUN_W'(ZRUN_MAX);
      else                                   zl_eff = zrun_len;
   end
   assign zrun_on = (zl_eff != '0);

   assign raw_bit  = inz_cur ? 1'b0 : msb_v[order];
   assign zrun_act = inz_cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= '1;
         pcnt_q <= '0;
         zcnt_q <= '0;
         inz_q  <= 1'b0;
      end else begin
         st_q   <= st_cur;
         pcnt_q <= pcnt_cur;
         zcnt_q <= zcnt_cur;
         inz_q  <= inz_cur;
         if (adv) begin
            if (inz_cur) begin
               if (zcnt_cur + ZRUN_W'(1) >= zl_eff) begin
                  inz_q  <= 1'b0;
                  zcnt_q <= '0;
               end else begin
                  zcnt_q <= zcnt_cur + ZRUN_W'(1);
               end
            end else begin
               st_q <= nxt_v[order];
               if (last_v[order]) begin
                  pcnt_q <= '0;
                  inz_q  <= zrun_on;
               end else begin
                  pcnt_q <= pcnt_cur + W'(1);
               end
            end
         end
      end
   end

endmodule

// File: rtl/patsrc_user.sv
module patsrc_user #(
   parameter int NUM   = 8,
   parameter int PW    = 32,
   parameter int IDX_W = $clog2(NUM),
   parameter int LEN_W = $clog2(PW + 1),
   parameter logic [NUM*PW-1:0]    PATS = '0,
   parameter logic [NUM*LEN_W-1:0] LENS = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             restart,
   input  logic [IDX_W-1:0] sel,
   output logic             raw_bit
);

   localparam int PTR_W = $clog2(PW);

   logic [PW-1:0]    pat_a [NUM];
   logic [LEN_W-1:0] len_a [NUM];
   logic [PTR_W-1:0] ptr_q, ptr_cur;
   logic [LEN_W-1:0] len_sel;
   logic [PW-1:0]    pat_sel;
   logic             wrap;

   for (genvar g = 0; g < NUM; g++) begin : g_preset
      localparam int L = int'(LENS[g*LEN_W +: LEN_W]);
      if (L < 3 || L > PW) begin : g_bad_len
         $error("user preset length out of range");
      end
      assign pat_a[g] = PATS[g*PW +: PW];
      assign len_a[g] = LENS[g*LEN_W +: LEN_W];
   end

   assign ptr_cur = restart ? '0 : ptr_q;
   assign len_sel = len_a[sel];
   assign pat_sel = pat_a[sel];
   assign raw_bit = pat_sel[ptr_cur];
   assign wrap    = (LEN_W'(ptr_cur) == len_sel - LEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr_q <= '0;
      else if (adv) ptr_q <= wrap ? '0 : ptr_cur + PTR_W'(1);
      else          ptr_q <= ptr_cur;
   end

endmodule

// File: rtl/patsrc_impair.sv
module patsrc_impair #(
   parameter int DIV_W   = 32,
   parameter bit RATE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             err_one,
   input  logic [DIV_W-1:0] div,
   output logic             flip
);

   if (DIV_W < 2) begin : g_bad_div_w
      $error("DIV_W must be at least 2");
   end

   logic pend_q;
   logic one_fire;
   logic rate_fire;

   assign one_fire = step & (pend_q | err_one);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= (pend_q | err_one) & ~step;
   end

   if (RATE_EN) begin : g_rate
      logic [DIV_W-1:0] rcnt_q;
      logic             rate_on;
      assign rate_on   = (div != '0);
      assign rate_fire = step & rate_on & (rcnt_q >= div - DIV_W'(1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       rcnt_q <= '0;
         else if (!rate_on) rcnt_q <= '0;
         else if (step)    rcnt_q <= rate_fire ? '0 : rcnt_q + DIV_W'(1);
      end
   end else begin : g_no_rate
      assign rate_fire = 1'b0;
   end

   assign flip = one_fire | rate_fire;

endmodule

// File: rtl/patsrc_top.sv
module patsrc_top
   import patsrc_pkg::*;
#(
   parameter int NUM_PRESETS = 8,
   parameter int UPAT_W      = 32,
   parameter int DIV_W       = 32,
   parameter int ZRUN_W      = 11,
   parameter bit RATE_EN     = 1'b1,
   parameter logic [NUM_PRESETS*UPAT_W-1:0] USER_PAT = {
      32'hDEAD_BEEF, 32'h5A3C_96E1, 32'h00C3_A55A, 32'h0000_F00D,
      32'h0000_1B2D, 32'h0000_00B4, 32'h0000_0016, 32'h0000_0005},
   parameter logic [NUM_PRESETS*$clog2(UPAT_W+1)-1:0] USER_LEN = {
      6'd32, 6'd31, 6'd24, 6'd16, 6'd13, 6'd8, 6'd5, 6'd3}
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           step_en,
   input  logic [2:0]                     mode_sel,
   input  logic [$clog2(NUM_PRESETS)-1:0] preset_idx,
   input  logic                           err_one,
   input  logic [DIV_W-1:0]               err_div,
   input  logic [ZRUN_W-1:0]              zrun_len,
   input  logic                           invert,
   output logic                           bit_out,
   output logic                           bit_vld
);

   localparam int IDX_W = $clog2(NUM_PRESETS);
   localparam int LEN_W = $clog2(UPAT_W + 1);
   localparam int CFG_W = 3 + IDX_W;

   if (NUM_PRESETS < 2) begin : g_bad_presets
      $error("NUM_PRESETS must be at least 2");
   end
   if (UPAT_W < 3) begin : g_bad_upat_w
      $error("UPAT_W must be at least 3");
   end

   logic [CFG_W-1:0] cfg_now, cfg_q;
   logic             restart;
   logic             user_mode;
   logic             p_bit, u_bit, raw_bit;
   logic             zrun_act;
   logic             flip_w;
   logic             out_q, vld_q;

   assign cfg_now   = {mode_sel, preset_idx};
   assign restart   = (cfg_now != cfg_q);
   assign user_mode = mode_sel[2];

   patsrc_prbs #(.ZRUN_W(ZRUN_W)) u_prbs (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (step_en & ~user_mode),
      .restart  (restart),
      .order    (seq_order_e'(mode_sel[1:0])),
      .zrun_len (zrun_len),
      .raw_bit  (p_bit),
      .zrun_act (zrun_act)
   );

   patsrc_user #(
      .NUM   (NUM_PRESETS),
      .PW    (UPAT_W),
      .IDX_W (IDX_W),
      .LEN_W (LEN_W),
      .PATS  (USER_PAT),
      .LENS  (USER_LEN)
   ) u_user (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (step_en & user_mode),
      .restart (restart),
      .sel     (preset_idx),
      .raw_bit (u_bit)
   );

   patsrc_impair #(.DIV_W(DIV_W), .RATE_EN(RATE_EN)) u_imp (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step_en),
      .err_one (err_one),
      .div     (err_div),
      .flip    (flip_w)
   );

   assign raw_bit = user_mode ? u_bit : p_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         out_q <= 1'b0;
         vld_q <= 1'b0;
      end else begin
         cfg_q <= cfg_now;
         vld_q <= step_en;
         if (step_en) out_q <= raw_bit ^ flip_w ^ invert;
      end
   end

   assign bit_out = out_q;
   assign bit_vld = vld_q;

endmodule

// File: rtl/patsrc_chk.sv
module patsrc_chk #(
   parameter int DIV_W   = 32,
   parameter bit RATE_EN = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step_en,
   input logic [2:0]       mode_sel,
   input logic             err_one,
   input logic [DIV_W-1:0] err_div,
   input logic             invert,
   input logic             bit_out,
   input logic             bit_vld,
   input logic             zrun_act,
   input logic             flip_w
);

   AST_VLD_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |=> bit_vld);  // R1

   AST_VLD_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> !bit_vld);  // R1

   AST_ZRUN_EMITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && zrun_act && !flip_w) |=> (bit_out == $past(invert)));  // R5

   AST_NO_ZRUN_IN_USER: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel[2] |-> !zrun_act);  // R6

   AST_ONE_SHOT_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && err_one) |-> flip_w);  // R7

   AST_RATE_EVERY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (RATE_EN && step_en && err_div == DIV_W'(1)) |-> flip_w);  // R8

   AST_NO_FLIP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |-> !flip_w);  // R9

endmodule

bind patsrc_top patsrc_chk #(.DIV_W(DIV_W), .RATE_EN(RATE_EN)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .step_en  (step_en),
   .mode_sel (mode_sel),
   .err_one  (err_one),
   .err_div  (err_div),
   .invert   (invert),
   .bit_out  (bit_out),
   .bit_vld  (bit_vld),
   .zrun_act (zrun_act),
   .flip_w   (flip_w)
);

// File: tb/tb_patsrc_top.sv
module tb_patsrc_top;

   localparam logic [255:0] TB_PAT = {
      32'h9ABC_DEF1, 32'h1234_5679, 32'h00E1_7C3A, 32'h0000_C6A5,
      32'h0000_0F5B, 32'h0000_0071, 32'h0000_000D, 32'h0000_0006};
   localparam logic [47:0]  TB_LEN = {
      6'd32, 6'd29, 6'd20, 6'd16, 6'd12, 6'd7, 6'd4, 6'd3};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_en = 1'b0;
   logic [2:0]  mode_sel = '0;
   logic [2:0]  preset_idx = '0;
   logic        err_one = 1'b0;
   logic [31:0] err_div = '0;
   logic [10:0] zrun_len = '0;
   logic        invert = 1'b0;
   logic        bit_out, bit_vld;

   always #2.5 clk = ~clk;

   patsrc_top #(.USER_PAT(TB_PAT), .USER_LEN(TB_LEN)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_en    (step_en),
      .mode_sel   (mode_sel),
      .preset_idx (preset_idx),
      .err_one    (err_one),
      .err_div    (err_div),
      .zrun_len   (zrun_len),
      .invert     (invert),
      .bit_out    (bit_out),
      .bit_vld    (bit_vld)
   );

   typedef struct {
      bit    vld;
      bit    val;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   mon_on = 1'b0;
   bit   done = 1'b0;

   // reference model state
   logic [22:0] m_st = '1;
   int          m_pc = 0, m_zc = 0, m_ptr = 0;
   bit          m_inz = 0, m_pend = 0;
   longint      m_rc = 0;
   logic [5:0]  m_cfg = '0;

   task automatic cyc(input bit st, input logic [2:0] md, input logic [2:0] pr,
                      input bit e1, input logic [31:0] dv, input logic [10:0] zl,
                      input bit inv, input string tag);
      bit raw, one, rf, rst;
      int n, t, zeff, len;
      exp_t e;
      step_en = st; mode_sel = md; preset_idx = pr; err_one = e1;
      err_div = dv; zrun_len = zl; invert = inv;
      rst = ({md, pr} != m_cfg);                       // R4
      m_cfg = {md, pr};
      if (rst) begin m_st = '1; m_pc = 0; m_zc = 0; m_inz = 0; m_ptr = 0; end
      if (md[2]) begin                                 // R3
         len = int'(TB_LEN[pr*6 +: 6]);
         raw = TB_PAT[pr*32 + m_ptr];
         if (st) m_ptr = (m_ptr == len - 1) ? 0 : m_ptr + 1;
      end else begin                                   // R2, R5
         case (md[1:0])
            2'd0: begin n = 7;  t = 6;  end
            2'd1: begin n = 11; t = 9;  end
            2'd2: begin n = 15; t = 14; end
            default: begin n = 23; t = 18; end
         endcase
         zeff = (zl < 8) ? 0 : (zl > 2040) ? 2040 : int'(zl);
         raw = m_inz ? 1'b0 : m_st[n-1];
         if (st) begin
            if (m_inz) begin
               m_zc++;
               if (m_zc >= zeff) begin m_inz = 0; m_zc = 0; end
            end else begin
               bit fb;
               fb = m_st[n-1] ^ m_st[t-1];
               m_st = {m_st[21:0], 1'b0};
               m_st[0] = fb;
               m_st[22] = (n == 23) ? m_st[22] : 1'b1;
               if (m_pc == (1 << n) - 2) begin m_pc = 0; m_inz = (zeff != 0); end
               else m_pc++;
            end
         end
      end
      one = st && (m_pend || e1);                      // R7
      m_pend = (m_pend || e1) && !st;
      if (dv == 0) begin rf = 0; m_rc = 0; end         // R8
      else begin
         rf = st && (m_rc >= longint'(dv) - 1);
         if (st) m_rc = rf ? 0 : m_rc + 1;
      end
      e.vld = st;
      e.val = raw ^ (one | rf) ^ inv;                  // R9, R10
      e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
   endtask

   task automatic run(input int cnt, input logic [2:0] md, input logic [2:0] pr,
                      input logic [31:0] dv, input logic [10:0] zl, input bit inv,
                      input int gap_pct, input string tag);
      for (int i = 0; i < cnt; i++)
         cyc(($urandom_range(99) >= gap_pct), md, pr, 1'b0, dv, zl, inv, tag);
   endtask

   // monitor: sample 1 ns after each rising edge
   initial begin
      forever begin
         @(posedge clk); #1;
         if (mon_on && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (bit_vld !== e.vld || (e.vld && bit_out !== e.val)) begin
               n_bad++;
               $display("FAIL %s: got vld=%0b bit=%0b, expected vld=%0b bit=%0b",
                        e.tag, bit_vld, bit_out, e.vld, e.val);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got no end of test, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;                                         // R1 reset state
      if (bit_vld !== 1'b0 || bit_out !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 reset: got vld=%0b bit=%0b, expected vld=0 bit=0", bit_vld, bit_out);
      end
      rst_n = 1'b1;
      mon_on = 1'b1;
      // R1 idle then R2 each order, with and without gaps
      run(10,  3'd0, 3'd0, 0, 0, 0, 100, "R1 idle");
      run(300, 3'd0, 3'd0, 0, 0, 0, 0,  "R2 order7");
      run(300, 3'd1, 3'd0, 0, 0, 0, 20, "R2 order11");
      run(300, 3'd2, 3'd0, 0, 0, 0, 0,  "R2 order15");
      run(300, 3'd3, 3'd0, 0, 0, 0, 30, "R2 order23");
      // R4 restart mid-stream on the same order via preset change
      run(50,  3'd0, 3'd1, 0, 0, 0, 0,  "R4 restart");
      run(50,  3'd0, 3'd2, 0, 0, 0, 0,  "R4 restart");
      // R5 zero runs: 8, disabled (3), clamped (2047)
      run(600,  3'd0, 3'd0, 0, 11'd8,    0, 0,  "R5 zrun8");
      run(300,  3'd0, 3'd3, 0, 11'd3,    0, 0,  "R5 zrun off");
      run(2500, 3'd0, 3'd4, 0, 11'd2047, 0, 10, "R5 zrun clamp");
      // R3 every preset; R6 zero-run length set in user mode
      for (int p = 0; p < 8; p++)
         run(80, 3'd4, 3'(p), 0, 11'd8, 0, 15, "R3 R6 user");
      // R7 single shots: back to back and across stalls
      cyc(1, 3'd1, 3'd0, 0, 0, 0, 0, "R7 single");
      for (int i = 0; i < 200; i++)
         cyc((i % 3) != 0, 3'd1, 3'd0, ((i % 17) == 3) || ((i % 17) == 4),
             0, 0, 0, "R7 single");
      // R8 periodic; R9 overlap with single shots
      run(300, 3'd2, 3'd0, 32'd1,  0, 0, 0,  "R8 div1");
      run(300, 3'd2, 3'd0, 32'd5,  0, 0, 25, "R8 div5");
      for (int i = 0; i < 300; i++)
         cyc(1'b1, 3'd5, 3'd0, (i % 13) == 0, 32'd37, 11'd8, 0, "R9 overlap");
      run(100, 3'd2, 3'd0, 32'd0,  0, 0, 0,  "R8 div0");
      // R10 polarity, with zero runs and errors
      run(400, 3'd0, 3'd0, 32'd9, 11'd16, 1, 10, "R10 invert");
      run(5, 3'd0, 3'd0, 0, 0, 0, 100, "R1 drain");
      mon_on = 1'b0;
      n_chk++;
      if (exp_q.size() > 1) begin
         n_bad++;
         $display("FAIL R1 drain: got %0d pending, expected at most 1", exp_q.size());
      end
      finish_run();
   end

endmodule